// File: doc/BRIEF.md
# Synthesiser Lock-Loss Latch

This block watches the lock-detect pin of a radio frequency synthesiser and turns it into a clean, sticky out-of-lock status. The pin is asynchronous to the reference clock, so it is first brought into the clock domain by a flop chain. The polarity that means "in lock" is chosen by a static select input.

A short spike on the pin is treated as noise. An out-of-lock indication that lasts at least two reference-clock cycles is latched. This holds whether the indication is a brief pulse or a steady level. The latch stays set until a clear strobe arrives. While the latch is set, a transmit-inhibit output stops the transmitter from keying up on a carrier that may be off frequency. The transmit-inhibit output also rises in the cycle in which the out-of-lock condition first qualifies, one cycle before the flag does.

Top module: `lock_loss_guard`

## Requirements
- R1: After reset, both `out_of_lock_o` and `tx_inhibit_o` read 0.
- R2: With `lock_high_i` = 1, the pin reads as in lock when high and out of lock when low. With `lock_high_i` = 0, the meaning of the two levels is swapped.
- R3: An out-of-lock level that lasts only one reference-clock cycle never sets `out_of_lock_o`. A train of such one-cycle pulses separated by in-lock cycles does not set it either.
- R4: An out-of-lock level held for two or more consecutive reference-clock cycles sets `out_of_lock_o` within five clock cycles after the level ends.
- R5: Once set, `out_of_lock_o` stays at 1 after the pin returns to its in-lock level, for as long as no clear strobe arrives.
- R6: A one-cycle pulse on `clear_i` while the pin is in lock clears `out_of_lock_o` at the next clock edge.
- R7: When a qualified out-of-lock condition and `clear_i` occur in the same cycle, the set wins and `out_of_lock_o` stays at 1.
- R8: `tx_inhibit_o` is 1 whenever `out_of_lock_o` is 1. It also rises in the cycle in which an out-of-lock condition first qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_det_i | input | 1 | Raw lock-detect pin from the synthesiser (asynchronous) |
| lock_high_i | input | 1 | Polarity select: 1 = pin high means locked |
| clear_i | input | 1 | One-cycle strobe that clears the sticky flag |
| out_of_lock_o | output | 1 | Sticky out-of-lock flag |
| tx_inhibit_o | output | 1 | Transmit-inhibit output |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and a minimum qualifying width of two cycles. With these values, a one-cycle pulse and a two-cycle pulse fall on opposite sides of the threshold, so the single-cycle boundary can be tested directly. Both polarity settings are swept across pulse widths from zero to six cycles. The bench also drives a steady out-of-lock level while the clear strobe is pulsed, which puts the set-over-clear priority within reach.

// File: rtl/lkmon_pkg.sv
package lkmon_pkg;

  // Map the raw pin onto an "out of lock" level given the polarity select.
  function automatic logic loss_level(input logic pin, input logic lock_high);
    return pin ^ lock_high;
  endfunction

  // Saturating run-length step: counts consecutive loss cycles up to cap.
  function automatic int unsigned run_step(input int unsigned run,
                                           input logic        loss,
                                           input int unsigned cap);
    if (!loss)      return 0;
    if (run >= cap) return cap;
    return run + 1;
  endfunction

endpackage

// File: rtl/lkmon_sync.sv
module lkmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lkmon_qualify.sv
module lkmon_qualify
  import lkmon_pkg::*;
#(
  parameter int unsigned MIN_PULSE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loss_i,
  output logic qual_o
);
  localparam int unsigned CAP = MIN_PULSE - 1;
  localparam int unsigned CW  = (CAP < 2) ? 1 : $clog2(CAP + 1);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    run_d = CW'(run_step(32'(run_q), loss_i, CAP));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  assign qual_o = loss_i && (32'(run_q) >= CAP);

  // R3: a qualified event needs loss in the previous cycle as well
  a_r3_needs_prior_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> $past(loss_i));
endmodule

// File: rtl/lkmon_latch.sv
module lkmon_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  a_r6_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  a_r4_rise_from_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));
endmodule

// File: rtl/lock_loss_guard.sv
module lock_loss_guard
  import lkmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_PULSE   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_det_i,
  input  logic lock_high_i,
  input  logic clear_i,
  output logic out_of_lock_o,
  output logic tx_inhibit_o
);
  logic loss_raw;
  logic loss_sync;
  logic qual_evt;
  logic flag;

  // Polarity applied before the synchroniser so that its reset value means "locked".
  assign loss_raw = loss_level(lock_det_i, lock_high_i);

  lkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (loss_raw),
    .q_o   (loss_sync)
  );

  lkmon_qualify #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .loss_i(loss_sync),
    .qual_o(qual_evt)
  );

  lkmon_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (qual_evt),
    .clr_i (clear_i),
    .flag_o(flag)
  );

  assign out_of_lock_o = flag;
  assign tx_inhibit_o  = flag | qual_evt;

  a_r8_inhibit_covers_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_of_lock_o |-> tx_inhibit_o);
  a_r8_inhibit_on_qualify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_evt |-> tx_inhibit_o);
  a_r3_flag_needs_sync_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_of_lock_o) |-> $past(loss_sync));
endmodule

// File: tb/sim_lock_loss_guard.sv
module sim_lock_loss_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1;
  logic pol = 1'b1;
  logic clr = 1'b0;
  logic ool, txi;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_loss_guard u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lock_det_i   (pin),
    .lock_high_i  (pol),
    .clear_i      (clr),
    .out_of_lock_o(ool),
    .tx_inhibit_o (txi)
  );

  // vector: {polarity, pulse width[3:0], expected flag}
  localparam logic [5:0] VEC [14] = '{
    {1'b1, 4'd0, 1'b0}, {1'b1, 4'd1, 1'b0}, {1'b1, 4'd2, 1'b1},
    {1'b1, 4'd3, 1'b1}, {1'b1, 4'd6, 1'b1}, {1'b0, 4'd0, 1'b0},
    {1'b0, 4'd1, 1'b0}, {1'b0, 4'd2, 1'b1}, {1'b0, 4'd4, 1'b1},
    {1'b0, 4'd6, 1'b1}, {1'b1, 4'd1, 1'b0}, {1'b0, 4'd1, 1'b0},
    {1'b1, 4'd5, 1'b1}, {1'b0, 4'd3, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    pol = 1'b1; pin = 1'b1;
    tick(3);
    chk("R1 flag in reset", ool, 1'b0);
    chk("R1 inhibit in reset", txi, 1'b0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 flag after reset", ool, 1'b0);
    chk("R1 inhibit after reset", txi, 1'b0);

    // Table: R2 polarity, R3 short pulses, R4 qualified pulses, R5 stickiness
    for (int i = 0; i < 14; i++) begin
      logic vp;
      logic [3:0] vw;
      logic ve;
      {vp, vw, ve} = VEC[i];
      pol = vp; pin = vp;     // in-lock idle level equals polarity bit
      tick(4);
      do_clear();
      tick(2);
      chk("R6 cleared before vector", ool, 1'b0);
      pin = ~vp;
      tick(int'(vw));
      pin = vp;
      tick(6);
      chk(ve ? "R4/R5 latched loss" : "R3 glitch ignored", ool, ve);
      chk("R8 inhibit follows flag", txi, ve);
      chk("R2 polarity flag", ool, (vw >= 2));
    end

    // R6: clear while locked
    do_clear();
    chk("R6 clear at next edge", ool, 1'b0);
    chk("R8 inhibit after clear", txi, 1'b0);

    // R3: train of one-cycle glitches
    pol = 1'b1; pin = 1'b1;
    tick(3);
    for (int k = 0; k < 8; k++) begin
      pin = 1'b0; tick(1);
      pin = 1'b1; tick(1);
    end
    tick(6);
    chk("R3 glitch train ignored", ool, 1'b0);
    chk("R3 glitch train no inhibit", txi, 1'b0);

    // R7: steady loss while clearing, set wins
    pin = 1'b0;
    tick(8);
    chk("R4 steady loss latched", ool, 1'b1);
    do_clear();
    chk("R7 set beats clear", ool, 1'b1);
    tick(2);
    chk("R7 still set after clear", ool, 1'b1);
    chk("R8 inhibit during steady loss", txi, 1'b1);

    // R5: release, stays set until clear
    pin = 1'b1;
    tick(10);
    chk("R5 sticky after recovery", ool, 1'b1);
    do_clear();
    chk("R6 clear after recovery", ool, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule